// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex byte-wide serial port without framing. One line carries data out, one carries data in, and a shift clock pin is either driven by the port or received from a peer. Software-facing logic sees a one-byte transmit holding register with an empty flag, a one-byte receive holding register with a full flag, and an overrun flag. Each byte is eight NRZ bits, least significant bit first, with no start, stop or parity bit.

With the internal clock selected, a byte waiting in the transmit register starts a burst of exactly eight shift clocks. Each clock half-period lasts one `baud_tick` strobe. The same clock shifts in the incoming byte. With the external clock selected, the port follows a peer's clock. That clock, and the data input, pass through a two-flop synchronizer before edges are detected. The data output changes on falling edges, and the data input is sampled on rising edges. The clock and data lines rest high (mark) between bytes.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, `tx_empty`=1, `rx_full`=0, `overrun`=0, `sclk_o`=1, `sdo`=1, `tx_irq`=0 and `rx_irq`=0 while their enables are 0.
- R2: In internal mode with `tx_en`=1 and an idle shifter, a write drops `tx_empty` on the next cycle, and the byte moves to the shifter on the cycle after that, setting `tx_empty` again. Each byte produces exactly 8 falling edges on `sclk_o`. With `tx_en`=0, no clock runs and `tx_empty` stays 0. `tx_empty` falls only because of a write.
- R3: Bit 0 of the byte is sent first. `sdo` changes on the falling edge of `sclk_o` and is stable at the rising edge. The byte collected at the rising edges equals the byte written.
- R4: In internal mode, the data input is sampled at each rising clock edge. After the eighth bit, the byte appears on `rd_data` and `rx_full` is 1.
- R5: In internal mode, when no burst is active, `sclk_o` and `sdo` are both 1 (mark).
- R6: In external mode, eight peer clocks move one byte in each direction. The pending transmit byte is taken at the first falling edge, which sets `tx_empty`. With nothing to send (`tx_en`=0), the port sends all ones (0xFF).
- R7: A read strobe `rd_en` clears `rx_full` on the next cycle, unless a byte completes in the same cycle.
- R8: When a byte completes while `rx_full`=1 and no read is made, `overrun` is set, the new byte is dropped and `rd_data` keeps the old byte.
- R9: An `err_clr` strobe clears `overrun` on the next cycle, unless a new overrun occurs in the same cycle.
- R10: `tx_irq` = `tx_irq_en` AND `tx_empty`. `rx_irq` = `rx_irq_en` AND (`rx_full` OR `overrun`).
- R11: With `rx_en`=0, completed bytes are discarded and `rx_full` stays 0.
- R12: `sclk_oe` follows `int_clk` (1 = clock pin driven, internal clock). `sdo_oe` follows `dout_en`. In external mode, `sclk_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe marking each internal clock half-period |
| int_clk | input | 1 | 1: drive the shift clock; 0: follow `sclk_i` |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| dout_en | input | 1 | Data output enable |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| wr_en | input | 1 | Write strobe for the transmit register |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Read strobe for the receive register |
| rd_data | output | DATA_W | Received byte |
| err_clr | input | 1 | Clears the overrun flag |
| tx_empty | output | 1 | Transmit register empty |
| rx_full | output | 1 | Receive register full |
| overrun | output | 1 | Overrun error flag |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| sclk_i | input | 1 | Shift clock from the peer |
| sclk_o | output | 1 | Shift clock driven by the port |
| sclk_oe | output | 1 | Output enable for the shift clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data pin |

## Verification
The transmit flags have exact timing. `tx_empty` reads 0 one cycle after the write edge and 1 again one cycle later, and the bench samples it at the falling clock edges in between. Burst results depend on the strobe spacing: one tick every four cycles, seventeen ticks per byte including the closing mark tick. For these, the bench waits on `rx_full` with a bounded loop and then checks the byte, the collected serial bits and the clock count. It also waits a fixed margin past the last tick before checking the mark level. In external mode, `rd_data` and `tx_empty` are checked eight cycles after the peer's last rising edge, which exceeds the three-cycle synchronizer and edge-detect latency. Read and clear strobes are checked one cycle after they are applied.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int unsigned SSP_DW     = 8;
    localparam int unsigned SSP_STAGES = 2;
    typedef enum logic {PH_FALL = 1'b0, PH_RISE = 1'b1} phase_e;
endpackage

// File: rtl/ssp_sync_edge.sv
module ssp_sync_edge #(
    parameter int unsigned STAGES = ssp_pkg::SSP_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic din,
    output logic rise,
    output logic fall,
    output logic dout
);
    typedef struct packed {
        logic [STAGES:0]   ck;
        logic [STAGES-1:0] dt;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ck = {s_q.ck[STAGES-1:0], sclk_in};
        s_d.dt = {s_q.dt[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign rise = s_q.ck[STAGES-1] & ~s_q.ck[STAGES];
    assign fall = ~s_q.ck[STAGES-1] & s_q.ck[STAGES];
    assign dout = s_q.dt[STAGES-1];
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int unsigned DATA_W = ssp_pkg::SSP_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_clk,
    input  logic              tick,
    input  logic              ext_rise,
    input  logic              ext_fall,
    input  logic              sdi_s,
    input  logic              load_req,
    input  logic [DATA_W-1:0] load_data,
    output logic              load_ack,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sclk_o,
    output logic              sdo,
    output logic              active
);
    import ssp_pkg::*;
    localparam int unsigned CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);
    localparam logic [CW-1:0] TAIL = CW'(DATA_W);

    typedef struct packed {
        logic              active;
        phase_e            phase;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
        logic              sclk;
        logic              sdo;
    } shf_t;

    shf_t s_d, s_q;
    logic [DATA_W-1:0] word;

    always_comb begin
        s_d      = s_q;
        load_ack = 1'b0;
        done     = 1'b0;
        word     = '1;
        if (int_clk) begin
            if (!s_q.active) begin
                s_d.sclk = 1'b1;
                s_d.sdo  = 1'b1;
                if (load_req) begin
                    load_ack     = 1'b1;
                    s_d.tx_sh    = load_data;
                    s_d.active   = 1'b1;
                    s_d.cnt      = '0;
                    s_d.phase    = PH_FALL;
                end
            end else if (tick) begin
                if (s_q.cnt == TAIL) begin
                    s_d.sdo    = 1'b1;
                    s_d.active = 1'b0;
                    s_d.cnt    = '0;
                end else if (s_q.phase == PH_FALL) begin
                    s_d.sclk  = 1'b0;
                    s_d.sdo   = s_q.tx_sh[0];
                    s_d.phase = PH_RISE;
                end else begin
                    s_d.sclk  = 1'b1;
                    s_d.rx_sh = {sdi_s, s_q.rx_sh[DATA_W-1:1]};
                    s_d.tx_sh = {1'b1, s_q.tx_sh[DATA_W-1:1]};
                    s_d.cnt   = s_q.cnt + 1'b1;
                    s_d.phase = PH_FALL;
                    done      = (s_q.cnt == LAST);
                end
            end
        end else begin
            s_d.sclk   = 1'b1;
            s_d.active = 1'b0;
            if (ext_fall) begin
                if (s_q.cnt == '0) begin
                    load_ack  = load_req;
                    word      = load_req ? load_data : '1;
                    s_d.tx_sh = word;
                    s_d.sdo   = word[0];
                end else begin
                    s_d.sdo = s_q.tx_sh[0];
                end
            end
            if (ext_rise) begin
                s_d.rx_sh = {sdi_s, s_q.rx_sh[DATA_W-1:1]};
                s_d.tx_sh = {1'b1, s_q.tx_sh[DATA_W-1:1]};
                if (s_q.cnt == LAST) begin
                    done    = 1'b1;
                    s_d.cnt = '0;
                    s_d.sdo = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.sclk   <= 1'b1;
            s_q.sdo    <= 1'b1;
            s_q.tx_sh  <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_byte = s_d.rx_sh;
    assign sclk_o  = s_q.sclk;
    assign sdo     = s_q.sdo;
    assign active  = s_q.active;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
    parameter int unsigned DATA_W = ssp_pkg::SSP_DW,
    parameter int unsigned STAGES = ssp_pkg::SSP_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              int_clk,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              dout_en,
    input  logic              tx_irq_en,
    input  logic              rx_irq_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              err_clr,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              overrun,
    output logic              tx_irq,
    output logic              rx_irq,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe
);
    typedef struct packed {
        logic              tx_full;
        logic [DATA_W-1:0] tx_buf;
        logic              rx_full;
        logic [DATA_W-1:0] rx_buf;
        logic              ovr;
    } port_t;

    port_t p_d, p_q;

    logic              ext_rise, ext_fall, sdi_s;
    logic              load_ack, byte_done, shf_active;
    logic [DATA_W-1:0] rx_byte;

    ssp_sync_edge #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk_i),
        .din     (sdi),
        .rise    (ext_rise),
        .fall    (ext_fall),
        .dout    (sdi_s)
    );

    ssp_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_clk   (int_clk),
        .tick      (baud_tick),
        .ext_rise  (ext_rise),
        .ext_fall  (ext_fall),
        .sdi_s     (sdi_s),
        .load_req  (p_q.tx_full & tx_en),
        .load_data (p_q.tx_buf),
        .load_ack  (load_ack),
        .done      (byte_done),
        .rx_byte   (rx_byte),
        .sclk_o    (sclk_o),
        .sdo       (sdo),
        .active    (shf_active)
    );

    always_comb begin
        p_d = p_q;
        if (load_ack) p_d.tx_full = 1'b0;
        if (wr_en) begin
            p_d.tx_full = 1'b1;
            p_d.tx_buf  = wr_data;
        end
        if (rd_en)   p_d.rx_full = 1'b0;
        if (err_clr) p_d.ovr     = 1'b0;
        if (byte_done && rx_en) begin
            if (p_q.rx_full && !rd_en) begin
                p_d.ovr = 1'b1;
            end else begin
                p_d.rx_buf  = rx_byte;
                p_d.rx_full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rd_data  = p_q.rx_buf;
    assign tx_empty = ~p_q.tx_full;
    assign rx_full  = p_q.rx_full;
    assign overrun  = p_q.ovr;
    assign tx_irq   = tx_irq_en & ~p_q.tx_full;
    assign rx_irq   = rx_irq_en & (p_q.rx_full | p_q.ovr);
    assign sclk_oe  = int_clk;
    assign sdo_oe   = dout_en;
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
    parameter int unsigned DATA_W = ssp_pkg::SSP_DW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              tx_empty,
    input logic              rd_en,
    input logic              rx_full,
    input logic [DATA_W-1:0] rd_data,
    input logic              overrun,
    input logic              err_clr,
    input logic              byte_done,
    input logic              int_clk,
    input logic              sclk_o,
    input logic              sdo,
    input logic              shf_active
);
    // R2
    empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_en));

    // R5
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clk && !shf_active) |-> (sclk_o && sdo));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !byte_done) |=> !rx_full);

    // R8
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> (rx_full && $stable(rd_data)));

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !byte_done) |=> !overrun);

    // R12
    ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_clk |-> sclk_o);
endmodule

bind sync_serial_port ssp_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .tx_empty   (tx_empty),
    .rd_en      (rd_en),
    .rx_full    (rx_full),
    .rd_data    (rd_data),
    .overrun    (overrun),
    .err_clr    (err_clr),
    .byte_done  (byte_done),
    .int_clk    (int_clk),
    .sclk_o     (sclk_o),
    .sdo        (sdo),
    .shf_active (shf_active)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       int_clk = 1'b1, tx_en = 1'b1, rx_en = 1'b1, dout_en = 1'b1;
    logic       tx_irq_en = 1'b0, rx_irq_en = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, err_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tx_empty, rx_full, overrun, tx_irq, rx_irq;
    logic       sclk_i = 1'b1, sclk_o, sclk_oe, sdo, sdo_oe;
    logic       peer_sdi = 1'b1, lb = 1'b1;
    logic       sdi;

    int errors = 0;
    int checks = 0;
    int falls  = 0;
    int tcnt   = 0;
    logic [7:0] cap = 8'h00;

    assign sdi = lb ? sdo : peer_sdi;

    always #2.5 clk = ~clk;

    sync_serial_port u_sync_serial_port (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .int_clk(int_clk),
        .tx_en(tx_en), .rx_en(rx_en), .dout_en(dout_en),
        .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .err_clr(err_clr), .tx_empty(tx_empty), .rx_full(rx_full),
        .overrun(overrun), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // one tick every four cycles
    always @(negedge clk) begin
        tcnt      <= (tcnt == 3) ? 0 : tcnt + 1;
        baud_tick <= (tcnt == 3);
    end

    // peer view of the driven clock
    always @(negedge sclk_o) falls = falls + 1;
    always @(posedge sclk_o) cap = {sdo, cap[7:1]};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] v);
        @(negedge clk) wr_en = 1'b1; wr_data = v;
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic read_byte();
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic wait_full();
        for (int n = 0; n < 300 && !rx_full; n++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // internal burst, written byte v; leaves sampling at a negedge
    task automatic int_send(input logic [7:0] v, input bit strict);
        falls = 0;
        write_byte(v);
        if (strict) chk(tx_empty == 1'b0, "R2 empty drop", tx_empty, 0);
        @(negedge clk);
        if (strict) chk(tx_empty == 1'b1, "R2 load", tx_empty, 1);
    endtask

    // external transfer driven by the bench as clock master
    task automatic ext_xfer(input logic [7:0] send, output logic [7:0] got, output bit quiet);
        quiet = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) sclk_i = 1'b0; peer_sdi = send[i];
            repeat (8) begin @(negedge clk); if (!sclk_o) quiet = 1'b0; end
            sclk_i = 1'b1;
            got[i] = sdo;
            repeat (8) begin @(negedge clk); if (!sclk_o) quiet = 1'b0; end
        end
    endtask

    task automatic run_all();
        logic [7:0] got;
        bit quiet;

        // R1 reset state
        idle(3);
        chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
        chk(rx_full == 1'b0, "R1 rx_full", rx_full, 0);
        chk(overrun == 1'b0, "R1 overrun", overrun, 0);
        chk(sclk_o == 1'b1 && sdo == 1'b1, "R1 mark", {sclk_o, sdo}, 3);
        chk(tx_irq == 1'b0 && rx_irq == 1'b0, "R1 irq", {tx_irq, rx_irq}, 0);
        rst_n = 1'b1;
        idle(4);

        // R2 R3 R4 R5 R7: internal loopback over every byte value
        for (int v = 0; v < 256; v++) begin
            int_send(8'(v), 1'b1);
            wait_full();
            chk(rx_full == 1'b1, "R4 rx_full", rx_full, 1);
            chk(rd_data == 8'(v), "R4 rx byte", rd_data, v);
            chk(cap == 8'(v), "R3 lsb first", cap, v);
            chk(falls == 8, "R2 clock count", falls, 8);
            idle(8);
            chk(sclk_o == 1'b1 && sdo == 1'b1, "R5 mark idle", {sclk_o, sdo}, 3);
            read_byte();
            chk(rx_full == 1'b0, "R7 read clears", rx_full, 0);
        end

        // R10 interrupt gating
        tx_irq_en = 1'b1; idle(1);
        chk(tx_irq == 1'b1, "R10 tx irq on", tx_irq, 1);
        tx_irq_en = 1'b0; idle(1);
        chk(tx_irq == 1'b0, "R10 tx irq off", tx_irq, 0);

        // R8 R9 overrun and clear
        int_send(8'h3C, 1'b0); wait_full(); idle(8);
        chk(rx_irq == 1'b0, "R10 rx irq masked", rx_irq, 0);
        rx_irq_en = 1'b1; idle(1);
        chk(rx_irq == 1'b1, "R10 rx irq on", rx_irq, 1);
        int_send(8'hC5, 1'b0); idle(90);
        chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
        chk(rd_data == 8'h3C, "R8 old byte kept", rd_data, 8'h3C);
        chk(rx_full == 1'b1, "R8 still full", rx_full, 1);
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        chk(overrun == 1'b0, "R9 clear", overrun, 0);
        read_byte();
        rx_irq_en = 1'b0;

        // R11 receive disabled
        rx_en = 1'b0;
        int_send(8'h96, 1'b0); idle(90);
        chk(rx_full == 1'b0, "R11 rx disabled", rx_full, 0);
        chk(cap == 8'h96, "R11 tx still sent", cap, 8'h96);
        rx_en = 1'b1;

        // R2 transmit disabled holds the byte
        tx_en = 1'b0;
        int_send(8'h5A, 1'b0); idle(100);
        chk(falls == 0, "R2 no clock when tx off", falls, 0);
        chk(tx_empty == 1'b0, "R2 byte held", tx_empty, 0);
        tx_en = 1'b1;
        wait_full();
        chk(rd_data == 8'h5A, "R2 held byte sent", rd_data, 8'h5A);
        idle(8); read_byte();

        // R12 pin directions
        dout_en = 1'b0; idle(1);
        chk(sdo_oe == 1'b0 && sclk_oe == 1'b1, "R12 oe internal", {sclk_oe, sdo_oe}, 2);
        dout_en = 1'b1;

        // R6 external clock, every byte value
        int_clk = 1'b0; lb = 1'b0; idle(2);
        chk(sclk_oe == 1'b0, "R12 oe external", sclk_oe, 0);
        for (int v = 0; v < 256; v++) begin
            write_byte(8'(v));
            ext_xfer(8'(v) ^ 8'hA5, got, quiet);
            chk(got == 8'(v), "R6 ext tx byte", got, v);
            chk(rd_data == (8'(v) ^ 8'hA5), "R6 ext rx byte", rd_data, 8'(v) ^ 8'hA5);
            chk(tx_empty == 1'b1, "R6 ext loaded", tx_empty, 1);
            chk(quiet, "R12 no drive external", quiet, 1);
            read_byte();
        end

        // R6 nothing to send gives all ones
        tx_en = 1'b0;
        ext_xfer(8'h81, got, quiet);
        chk(got == 8'hFF, "R6 idle ones", got, 8'hFF);
        chk(rd_data == 8'h81, "R6 rx only", rd_data, 8'h81);
        read_byte();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule